// File: doc/BRIEF.md
# ASID-Tagged Associative Translation Buffer

This block holds the tag side of a fully associative address-translation cache: a unified array of `UTLB_DEPTH` entries and a smaller instruction array of `ITLB_DEPTH` entries. Each entry stores a virtual page number, an address-space identifier, a valid bit, a dirty bit and a shared bit. A lookup compares every unified entry against a VPN/ASID key in parallel. It returns hit, the index of the matching entry and that entry's dirty bit in the same cycle.

Entries are filled by a load command. The command writes the slot chosen by a replacement counter, and only lookups advance that counter. A memory-mapped associative write searches both arrays with the same match rule. It rewrites the dirty and valid bits of the matching entries. It reports a multiple-hit exception when more than one unified entry matches. It requests a flush when a live instruction entry is invalidated.

The ASID comparison is skipped for shared entries. It is also skipped while single-virtual-space mode is on and the processor is privileged.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry of both arrays is invalid and the replacement counter is 0. `hit`, `mhit_exc` and `flush_req` are 0 and `exc_code` is 0.
- R2: An entry whose valid bit is 0 never matches, whatever its VPN, ASID or shared bit.
- R3: The ASID is compared only when `single_vspace` is 0 or `cpu_priv` is 0 (user mode). When both are 1, an entry matches on VPN alone.
- R4: An entry whose shared bit is 1 matches on VPN alone, even while ASID comparison is active.
- R5: While `lk_valid` is 1, `hit`, `hit_idx` and `hit_dirty` reflect the unified array in the same cycle. When several entries match, `hit_idx` is the lowest matching index.
- R6: The replacement counter rises by one at each clock edge where `lk_valid` is 1, and wraps from `UTLB_DEPTH-1` to 0.
- R7: A load (`ld_valid`=1) writes VPN, ASID, shared, valid and dirty into the unified slot named by the counter. With `ld_itlb`=1 it writes instead into instruction slot counter mod `ITLB_DEPTH`. A load never changes the counter.
- R8: An associative write (`aw_valid`=1) takes the new dirty bit from `aw_data` bit 9, the new valid bit from bit 8 and the match ASID from bits 7:0. If exactly one unified entry matches under the R2–R4 rule, its dirty and valid bits are replaced.
- R9: If two or more unified entries match an associative write, `mhit_exc` is 1 and `exc_code` is 0x140 in the next cycle, for one cycle. No entry of either array changes and no flush is requested.
- R10: An associative write without a multiple hit also writes the new valid bit into every matching instruction entry. If any such entry was valid and the new valid bit is 0, `flush_req` is 1 in the next cycle, for one cycle.
- R11: When `aw_valid` and `ld_valid` are both 1 in one cycle, the associative write is performed and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_vspace | input | 1 | Single-virtual-space mode bit |
| cpu_priv | input | 1 | Processor mode: 1 privileged, 0 user |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| hit | output | 1 | Lookup matched a unified entry |
| hit_idx | output | log2(UTLB_DEPTH) | Lowest matching unified index |
| hit_dirty | output | 1 | Dirty bit of the hit entry |
| ld_valid | input | 1 | Load-entry command |
| ld_itlb | input | 1 | Load targets the instruction array |
| ld_vpn | input | VPN_W | VPN to load |
| ld_asid | input | ASID_W | ASID to load |
| ld_sh | input | 1 | Shared bit to load |
| ld_v | input | 1 | Valid bit to load |
| ld_d | input | 1 | Dirty bit to load |
| aw_valid | input | 1 | Associative write strobe |
| aw_vpn | input | VPN_W | VPN searched by the associative write |
| aw_data | input | ASID_W+2 | {dirty, valid, ASID} for the associative write |
| mhit_exc | output | 1 | Multiple-hit exception pulse |
| exc_code | output | 12 | 0x140 while `mhit_exc` is 1, else 0 |
| flush_req | output | 1 | Instruction-array flush request pulse |

## Verification
Lookup results are combinational. The bench drives the key just after a falling edge and samples two nanoseconds later, before the rising edge that moves the counter. Loads and associative writes take effect at the next rising edge. The exception and flush pulses are registered, so the bench samples them just after that edge and checks them again one cycle later to confirm they fell. The bench keeps its own model of the replacement counter, stepped once per lookup it issues, to predict where each load lands and when the counter wraps.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
   // exception code raised on a multiple unified match during an associative write
   localparam logic [11:0] EXC_MULTI_HIT = 12'h140;
endpackage

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam #(
   parameter int N      = 64,
   parameter int VPN_W  = 22,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
   input  logic [N-1:0][ASID_W-1:0] asid_tab,
   input  logic [N-1:0]             v_tab,
   input  logic [N-1:0]             sh_tab,
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [ASID_W-1:0]        key_asid,
   input  logic                     use_asid,
   output logic [N-1:0]             match
);
   for (genvar g = 0; g < N; g++) begin : g_row
      logic vpn_eq, asid_ok;
      assign vpn_eq  = (vpn_tab[g] == key_vpn);
      assign asid_ok = sh_tab[g] || !use_asid || (asid_tab[g] == key_asid);
      assign match[g] = v_tab[g] && vpn_eq && asid_ok;
   end
endmodule

// File: rtl/tlb_low_enc.sv
module tlb_low_enc #(
   parameter int N = 64,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
   parameter int N = 64,
   localparam int W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   logic [W-1:0] nxt;

   if ((N & (N - 1)) == 0) begin : g_pow2
      assign nxt = cnt + 1'b1;
   end else begin : g_cmp
      assign nxt = (cnt == W'(N - 1)) ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (adv) cnt <= nxt;
   end

   // R7
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt));

   // R6
   ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt == (($past(cnt) == W'(N - 1)) ? W'(0) : W'($past(cnt) + 1'b1))));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int UTLB_DEPTH = 64,
   parameter int ITLB_DEPTH = 4,
   parameter int VPN_W      = 22,
   parameter int ASID_W     = 8,
   localparam int IDX_W     = $clog2(UTLB_DEPTH),
   localparam int IIDX_W    = $clog2(ITLB_DEPTH),
   localparam int AW_W      = ASID_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_vspace,
   input  logic              cpu_priv,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic              hit_dirty,
   input  logic              ld_valid,
   input  logic              ld_itlb,
   input  logic [VPN_W-1:0]  ld_vpn,
   input  logic [ASID_W-1:0] ld_asid,
   input  logic              ld_sh,
   input  logic              ld_v,
   input  logic              ld_d,
   input  logic              aw_valid,
   input  logic [VPN_W-1:0]  aw_vpn,
   input  logic [AW_W-1:0]   aw_data,
   output logic              mhit_exc,
   output logic [11:0]       exc_code,
   output logic              flush_req
);
   import asid_tlb_pkg::*;

   if (UTLB_DEPTH < 2 || UTLB_DEPTH > 256) begin : g_bad_udepth
      $error("UTLB_DEPTH out of range");
   end
   if (ITLB_DEPTH < 2 || ITLB_DEPTH > UTLB_DEPTH) begin : g_bad_idepth
      $error("ITLB_DEPTH out of range");
   end
   if (VPN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("tag widths must be positive");
   end

   // unified array
   logic [UTLB_DEPTH-1:0][VPN_W-1:0]  u_vpn;
   logic [UTLB_DEPTH-1:0][ASID_W-1:0] u_asid;
   logic [UTLB_DEPTH-1:0]             u_v, u_d, u_sh;
   // instruction array
   logic [ITLB_DEPTH-1:0][VPN_W-1:0]  i_vpn;
   logic [ITLB_DEPTH-1:0][ASID_W-1:0] i_asid;
   logic [ITLB_DEPTH-1:0]             i_v, i_sh;

   logic                  use_asid;
   logic [UTLB_DEPTH-1:0] lk_match, aw_umatch;
   logic [ITLB_DEPTH-1:0] aw_imatch;
   logic                  lk_found, aw_multi, aw_new_v, aw_new_d;
   logic [IDX_W-1:0]      lk_idx, ctr;
   logic [IIDX_W-1:0]     ictr;
   logic [ASID_W-1:0]     aw_asid;
   logic                  mhit_q, flush_q;

   assign use_asid = !single_vspace || !cpu_priv;
   assign aw_new_d = aw_data[ASID_W+1];
   assign aw_new_v = aw_data[ASID_W];
   assign aw_asid  = aw_data[ASID_W-1:0];

   tlb_tag_cam #(.N(UTLB_DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_cam_lk (
      .vpn_tab(u_vpn), .asid_tab(u_asid), .v_tab(u_v), .sh_tab(u_sh),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .use_asid(use_asid), .match(lk_match));

   tlb_tag_cam #(.N(UTLB_DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_cam_uaw (
      .vpn_tab(u_vpn), .asid_tab(u_asid), .v_tab(u_v), .sh_tab(u_sh),
      .key_vpn(aw_vpn), .key_asid(aw_asid), .use_asid(use_asid), .match(aw_umatch));

   tlb_tag_cam #(.N(ITLB_DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_cam_iaw (
      .vpn_tab(i_vpn), .asid_tab(i_asid), .v_tab(i_v), .sh_tab(i_sh),
      .key_vpn(aw_vpn), .key_asid(aw_asid), .use_asid(use_asid), .match(aw_imatch));

   tlb_low_enc #(.N(UTLB_DEPTH)) i_enc (.vec(lk_match), .found(lk_found), .idx(lk_idx));

   tlb_repl_ctr #(.N(UTLB_DEPTH)) i_ctr (.clk(clk), .rst_n(rst_n), .adv(lk_valid), .cnt(ctr));

   if ((ITLB_DEPTH & (ITLB_DEPTH - 1)) == 0) begin : g_islot_pow2
      assign ictr = ctr[IIDX_W-1:0];
   end else begin : g_islot_mod
      assign ictr = IIDX_W'(ctr % IDX_W'(ITLB_DEPTH));
   end

   assign aw_multi = (aw_umatch & (aw_umatch - UTLB_DEPTH'(1))) != '0;

   logic aw_go, ld_go;
   assign aw_go = aw_valid && !aw_multi;
   assign ld_go = ld_valid && !aw_valid;

   // valid bits and event pulses (reset)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_v     <= '0;
         i_v     <= '0;
         mhit_q  <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         mhit_q  <= aw_valid && aw_multi;
         flush_q <= aw_go && !aw_new_v && (aw_imatch != '0);
         if (aw_go) begin
            for (int i = 0; i < UTLB_DEPTH; i++)
               if (aw_umatch[i]) u_v[i] <= aw_new_v;
            for (int i = 0; i < ITLB_DEPTH; i++)
               if (aw_imatch[i]) i_v[i] <= aw_new_v;
         end else if (ld_go) begin
            if (ld_itlb) i_v[ictr] <= ld_v;
            else         u_v[ctr]  <= ld_v;
         end
      end
   end

   // tag fields (no reset needed: gated by valid)
   always_ff @(posedge clk) begin
      if (aw_go) begin
         for (int i = 0; i < UTLB_DEPTH; i++)
            if (aw_umatch[i]) u_d[i] <= aw_new_d;
      end else if (ld_go) begin
         if (ld_itlb) begin
            i_vpn[ictr]  <= ld_vpn;
            i_asid[ictr] <= ld_asid;
            i_sh[ictr]   <= ld_sh;
         end else begin
            u_vpn[ctr]  <= ld_vpn;
            u_asid[ctr] <= ld_asid;
            u_sh[ctr]   <= ld_sh;
            u_d[ctr]    <= ld_d;
         end
      end
   end

   assign hit       = lk_valid && lk_found;
   assign hit_idx   = lk_idx;
   assign hit_dirty = hit && u_d[lk_idx];
   assign mhit_exc  = mhit_q;
   assign exc_code  = mhit_q ? EXC_MULTI_HIT : 12'h000;
   assign flush_req = flush_q;

   // R5
   hit_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> lk_match[hit_idx]);

   // R9
   mhit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mhit_exc |-> $past(aw_valid));

   // R10
   flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> ($past(aw_valid) && !$past(aw_data[ASID_W])));

   // R9
   mhit_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mhit_exc |-> !flush_req);
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
   localparam int UD = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        single_vspace = 1'b0, cpu_priv = 1'b0;
   logic        lk_valid = 1'b0;
   logic [21:0] lk_vpn = '0;
   logic [7:0]  lk_asid = '0;
   logic        hit, hit_dirty;
   logic [5:0]  hit_idx;
   logic        ld_valid = 1'b0, ld_itlb = 1'b0, ld_sh = 1'b0, ld_v = 1'b0, ld_d = 1'b0;
   logic [21:0] ld_vpn = '0;
   logic [7:0]  ld_asid = '0;
   logic        aw_valid = 1'b0;
   logic [21:0] aw_vpn = '0;
   logic [9:0]  aw_data = '0;
   logic        mhit_exc, flush_req;
   logic [11:0] exc_code;

   int total = 0, bad = 0, exp_ctr = 0;

   always #4 clk = ~clk;

   asid_tlb i_asid_tlb (
      .clk(clk), .rst_n(rst_n), .single_vspace(single_vspace), .cpu_priv(cpu_priv),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .hit(hit), .hit_idx(hit_idx), .hit_dirty(hit_dirty),
      .ld_valid(ld_valid), .ld_itlb(ld_itlb), .ld_vpn(ld_vpn), .ld_asid(ld_asid),
      .ld_sh(ld_sh), .ld_v(ld_v), .ld_d(ld_d),
      .aw_valid(aw_valid), .aw_vpn(aw_vpn), .aw_data(aw_data),
      .mhit_exc(mhit_exc), .exc_code(exc_code), .flush_req(flush_req));

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic lookup(input int vpn, input int asid, input bit sv, input bit priv,
                         input bit e_hit, input int e_idx, input bit e_dirty, input string req);
      @(negedge clk);
      single_vspace = sv; cpu_priv = priv;
      lk_valid = 1'b1; lk_vpn = 22'(vpn); lk_asid = 8'(asid);
      #2;
      chk(req, "hit", int'(hit), int'(e_hit));
      if (e_hit) begin
         chk(req, "hit_idx", int'(hit_idx), e_idx);
         chk(req, "hit_dirty", int'(hit_dirty), int'(e_dirty));
      end
      @(posedge clk);
      exp_ctr = (exp_ctr + 1) % UD;
      #1 lk_valid = 1'b0;
   endtask

   task automatic load(input bit itlb, input int vpn, input int asid,
                       input bit sh, input bit v, input bit d);
      @(negedge clk);
      ld_valid = 1'b1; ld_itlb = itlb; ld_vpn = 22'(vpn); ld_asid = 8'(asid);
      ld_sh = sh; ld_v = v; ld_d = d;
      @(posedge clk);
      #1 ld_valid = 1'b0;
   endtask

   task automatic awrite(input int vpn, input int asid, input bit v, input bit d,
                         input bit e_mhit, input bit e_flush, input string req);
      @(negedge clk);
      single_vspace = 1'b0; cpu_priv = 1'b0;
      aw_valid = 1'b1; aw_vpn = 22'(vpn); aw_data = {d, v, 8'(asid)};
      @(posedge clk);
      #1 aw_valid = 1'b0;
      #2;
      chk(req, "mhit_exc", int'(mhit_exc), int'(e_mhit));
      chk(req, "exc_code", int'(exc_code), e_mhit ? 'h140 : 0);
      chk(req, "flush_req", int'(flush_req), int'(e_flush));
      if (e_mhit || e_flush) begin
         @(posedge clk); #1;
         chk(req, "pulse end mhit", int'(mhit_exc), 0);
         chk(req, "pulse end flush", int'(flush_req), 0);
      end
   endtask

   task automatic t_reset;
      #2;
      chk("R1", "mhit_exc", int'(mhit_exc), 0);
      chk("R1", "flush_req", int'(flush_req), 0);
      chk("R1", "exc_code", int'(exc_code), 0);
      lookup(0, 0, 0, 0, 0, 0, 0, "R1");
   endtask

   task automatic t_load_keeps_ctr;
      // R7: both loads land in slot 1; the second overwrites the first
      load(0, 'h100, 5, 0, 1, 0);
      load(0, 'h200, 5, 0, 1, 0);
      lookup('h100, 5, 0, 0, 0, 0, 0, "R7");
      lookup('h200, 5, 0, 0, 1, 1, 0, "R7");
   endtask

   task automatic t_asid_mode;
      lookup('h200, 6, 1, 0, 0, 0, 0, "R3 user");
      lookup('h200, 6, 1, 1, 1, 1, 0, "R3 bypass");
      lookup('h200, 6, 0, 1, 0, 0, 0, "R3 sv0");
   endtask

   task automatic t_shared;
      load(0, 'h300, 9, 1, 1, 0);            // slot 6
      lookup('h300, 3, 0, 0, 1, 6, 0, "R4");
   endtask

   task automatic t_invalid;
      load(0, 'h400, 1, 1, 0, 0);            // slot 7, not valid
      lookup('h400, 1, 1, 1, 0, 0, 0, "R2");
   endtask

   task automatic t_lowest;
      load(0, 'h500, 2, 0, 1, 0);            // slot 8
      lookup('h500, 2, 0, 0, 1, 8, 0, "R5");
      load(0, 'h500, 2, 0, 1, 1);            // slot 9
      lookup('h500, 2, 0, 0, 1, 8, 0, "R5 lowest");
   endtask

   task automatic t_assoc_single;
      awrite('h200, 5, 1, 1, 0, 0, "R8");
      lookup('h200, 5, 0, 0, 1, 1, 1, "R8 dirty");
      awrite('h300, 3, 0, 0, 0, 0, "R8 shared inval");
      lookup('h300, 9, 0, 0, 0, 0, 0, "R8 inval");
   endtask

   task automatic t_multi;
      awrite('h500, 2, 0, 0, 1, 0, "R9");
      lookup('h500, 2, 0, 0, 1, 8, 0, "R9 unchanged");
   endtask

   task automatic t_flush;
      load(1, 'h600, 4, 0, 1, 0);            // instruction slot 13 mod 4 = 1
      awrite('h600, 4, 0, 0, 0, 1, "R10");
      awrite('h600, 4, 0, 0, 0, 0, "R10 now invalid");
      load(1, 'h700, 4, 0, 1, 0);
      awrite('h700, 4, 1, 0, 0, 0, "R10 keep valid");
   endtask

   task automatic t_priority;
      @(negedge clk);
      aw_valid = 1'b1; aw_vpn = 22'h900; aw_data = 10'h105;
      ld_valid = 1'b1; ld_itlb = 1'b0; ld_vpn = 22'h800; ld_asid = 8'h1;
      ld_sh = 1'b0; ld_v = 1'b1; ld_d = 1'b0;
      @(posedge clk);
      #1 aw_valid = 1'b0; ld_valid = 1'b0;
      lookup('h800, 1, 0, 0, 0, 0, 0, "R11");
   endtask

   task automatic t_wrap;
      while (exp_ctr != 0) lookup('h3fffff, 0, 0, 0, 0, 0, 0, "R6 fill");
      load(0, 'hA00, 7, 0, 1, 0);
      lookup('hA00, 7, 0, 0, 1, 0, 0, "R6 wrap");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_load_keeps_ctr();
      t_asid_mode();
      t_shared();
      t_invalid();
      t_lowest();
      t_assoc_single();
      t_multi();
      t_flush();
      t_priority();
      t_wrap();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule